// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block is the exception-control unit of a small 16-bit processor whose program counter is 22 bits wide. It watches two active-low interrupt pins, one fast and one normal. It also takes a strobe for each completed instruction, which drives single-step tracing, and decoded strobes for the software-interrupt instruction and the three return instructions. The block owns the 4-bit status word. It keeps three shadow banks, each holding a return address and a saved status: one bank for the fast class, one shared by the normal interrupt and trace, and one for software interrupts. The software-interrupt bank's address half is the return-address register A14, which is visible on `a14_out`.

On a hardware exception the sequencer saves state and updates the status bits at the accept edge. In the same cycle it issues a read of a vector word from program memory and stalls fetch. In the following cycle it loads the PC with that word, zero-extended to 22 bits. A software interrupt loads the PC in its own cycle, with no memory read. A return strobe restores the PC and status from the matching bank in its own cycle.

The design has no data stream with a producer and a consumer. The memory port is a fixed one-cycle read: `pm_rd_data` is taken, without a ready signal, in the cycle after `pm_rd_en`. Back-pressure runs in one direction only. While `stall` is high, the fetch stage must hold, and the decoder must not present instruction strobes.

Top module: `exc_seq`

## Requirements
- R1: After reset, `sr_out` is 0 and `pc_load`, `stall`, `pm_rd_en` and `swi_err` are all low.
- R2: Hardware exception entry takes two cycles. In the accept cycle, `pm_rd_en` and `stall` are high, `pc_load` is low, and `pm_rd_addr` is 2 for fast, 4 for normal or 6 for trace. In the next cycle, `pc_load` and `stall` are high, `pm_rd_en` is low, and `pc_new` = {6'b0, word read}.
- R3: Fast entry saves `cur_pc` and SR, then sets SR so that bit 3 (PM) = 1 and bits 0 (FE), 1 (IE) and 2 (TE) = 0. A `ret_fiq` strobe loads `pc_new` with the saved address in its own cycle and restores SR at the next edge.
- R4: Normal entry sets PM and clears IE and TE while keeping FE. `ret_irq` restores the address and SR from the normal bank.
- R5: When TE (bit 2) is set and `insn_retire` pulses, a trace exception follows, reading address 6. It saves into the normal bank, so `ret_irq` returns to the trace's `cur_pc`.
- R6: `swi_valid` with immediate n ≥ 2 loads `pc_new` = 4·n in the same cycle, with no memory read and no stall. It saves `cur_pc` into A14 (`a14_out`) and SR into the software bank, sets PM, clears IE and TE, and keeps FE. `ret_swi` restores the PC from A14 and restores SR.
- R7: `swi_valid` with immediate 0 or 1 raises `swi_err` in that cycle and does nothing else: no PC load, and no change to SR or A14.
- R8: When fast and normal requests are both acceptable, fast is taken first. The normal request stays pending.
- R9: A fast request is accepted only while FE = 1, and a normal request only while IE = 1. A falling edge seen while the enable is 0 stays pending and is taken once the enable is set.
- R10: Only a 1-to-0 transition creates a request. A pin held low produces exactly one entry.
- R11: `sr_we` loads `sr_wdata` into SR at the next edge when no exception, return or software interrupt is handled in that cycle.
- R12: A return or software-interrupt strobe in the run state takes precedence over an acceptable pending interrupt. The interrupt is taken on a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fiq_n | input | 1 | Fast interrupt request, active low, asynchronous |
| irq_n | input | 1 | Normal interrupt request, active low, asynchronous |
| insn_retire | input | 1 | One instruction completed this cycle |
| cur_pc | input | 22 | Return address to save (next instruction) |
| swi_valid | input | 1 | Software-interrupt instruction decoded |
| swi_imm | input | 6 | Software-interrupt immediate |
| ret_fiq | input | 1 | Fast-return instruction decoded |
| ret_irq | input | 1 | Normal/trace-return instruction decoded |
| ret_swi | input | 1 | Software-return instruction decoded |
| sr_we | input | 1 | Software write of the status word |
| sr_wdata | input | 4 | Status value to write |
| pm_rd_en | output | 1 | Program-memory read request |
| pm_rd_addr | output | 22 | Program-memory read address |
| pm_rd_data | input | 16 | Read word, valid the cycle after `pm_rd_en` |
| stall | output | 1 | Hold the fetch stage |
| pc_load | output | 1 | Load `pc_new` into the PC |
| pc_new | output | 22 | New PC value |
| sr_out | output | 4 | Status word: FE bit 0, IE bit 1, TE bit 2, PM bit 3 |
| a14_out | output | 22 | Software-interrupt return-address register |
| swi_err | output | 1 | Illegal software-interrupt immediate |

## Verification
Several properties are checked on every cycle: that the vector read is followed by a stalled PC load, that read addresses stay within the three vector words, that fast entry leaves PM set with FE, IE and TE cleared, that a pending request is held while its enable is off, that fast wins over normal, and that an illegal software interrupt never loads the PC. The end-to-end values need the bench's scenarios. These include the zero-extended vector word in the PC, the round trip through each shadow bank, the sweep of every software immediate, the single entry for a held-low pin, and the ordering of strobes against pending interrupts.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int SR_W = 4;
  localparam int FE_B = 0;
  localparam int IE_B = 1;
  localparam int TE_B = 2;
  localparam int PM_B = 3;

  typedef enum logic [1:0] {SRC_NONE, SRC_FIQ, SRC_IRQ, SRC_TRC} exc_src_e;
  typedef enum logic {ST_RUN, ST_VEC} seq_state_e;
endpackage

// File: rtl/exc_edge_det.sv
module exc_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic clr,
  output logic pend
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              fall;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= pin_n;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  assign fall = prev_q & ~sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend   <= 1'b0;
    end else begin
      prev_q <= sync_q[STAGES-1];
      pend   <= (pend & ~clr) | fall;
    end
endmodule

// File: rtl/exc_arb.sv
module exc_arb
  import exc_pkg::*;
#(
  parameter int PC_W     = 22,
  parameter int FIQ_VEC  = 2,
  parameter int IRQ_VEC  = 4,
  parameter int TRC_VEC  = 6
) (
  input  logic            fiq_ok,
  input  logic            irq_ok,
  input  logic            trc_ok,
  output exc_src_e        src,
  output logic [PC_W-1:0] vec_addr
);
  always_comb begin
    if (fiq_ok)      src = SRC_FIQ;
    else if (irq_ok) src = SRC_IRQ;
    else if (trc_ok) src = SRC_TRC;
    else             src = SRC_NONE;
  end

  always_comb begin
    case (src)
      SRC_FIQ: vec_addr = PC_W'(FIQ_VEC);
      SRC_IRQ: vec_addr = PC_W'(IRQ_VEC);
      SRC_TRC: vec_addr = PC_W'(TRC_VEC);
      default: vec_addr = '0;
    endcase
  end
endmodule

// File: rtl/exc_shadow.sv
module exc_shadow #(
  parameter int PC_W = 22,
  parameter int SR_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save,
  input  logic [PC_W-1:0] pc_in,
  input  logic [SR_W-1:0] sr_in,
  output logic [PC_W-1:0] pc_q,
  output logic [SR_W-1:0] sr_q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pc_q <= '0;
      sr_q <= '0;
    end else if (save) begin
      pc_q <= pc_in;
      sr_q <= sr_in;
    end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
#(
  parameter int PC_W        = 22,
  parameter int WORD_W      = 16,
  parameter int IMM_W       = 6,
  parameter int SYNC_STAGES = 2,
  parameter int FIQ_VEC     = 2,
  parameter int IRQ_VEC     = 4,
  parameter int TRC_VEC     = 6,
  parameter int SWI_MIN     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fiq_n,
  input  logic              irq_n,
  input  logic              insn_retire,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic              swi_valid,
  input  logic [IMM_W-1:0]  swi_imm,
  input  logic              ret_fiq,
  input  logic              ret_irq,
  input  logic              ret_swi,
  input  logic              sr_we,
  input  logic [3:0]        sr_wdata,
  output logic              pm_rd_en,
  output logic [PC_W-1:0]   pm_rd_addr,
  input  logic [WORD_W-1:0] pm_rd_data,
  output logic              stall,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_new,
  output logic [3:0]        sr_out,
  output logic [PC_W-1:0]   a14_out,
  output logic              swi_err
);
  localparam int NBANK  = 3;
  localparam int BK_FIQ = 0;
  localparam int BK_IRQ = 1;
  localparam int BK_SWI = 2;
  localparam int PAD_W  = PC_W - WORD_W;

  seq_state_e      st_q;
  logic [SR_W-1:0] sr_q;
  logic [1:0]      pin_n, pend, pend_clr;
  logic            fiq_pend, irq_pend, trc_pend;
  logic            run, ret_any, insn_evt, swi_legal, swi_go;
  logic            take_fiq, take_irq, take_trc, take_any;
  exc_src_e        src;
  logic [PC_W-1:0] vec_addr;
  logic [NBANK-1:0] bank_save;
  logic [PC_W-1:0] bank_pc [NBANK];
  logic [SR_W-1:0] bank_sr [NBANK];

  // request lines: index 0 fast, index 1 normal
  assign pin_n = {irq_n, fiq_n};
  generate
    for (genvar g = 0; g < 2; g++) begin : g_line
      exc_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin_n(pin_n[g]),
        .clr(pend_clr[g]), .pend(pend[g])
      );
    end
  endgenerate
  assign fiq_pend = pend[0];
  assign irq_pend = pend[1];

  assign run       = (st_q == ST_RUN);
  assign ret_any   = ret_fiq | ret_irq | ret_swi;
  assign insn_evt  = ret_any | swi_valid;
  assign swi_legal = (swi_imm >= IMM_W'(SWI_MIN));
  assign swi_go    = run & swi_valid & ~ret_any & swi_legal;
  assign swi_err   = run & swi_valid & ~ret_any & ~swi_legal;

  exc_arb #(.PC_W(PC_W), .FIQ_VEC(FIQ_VEC), .IRQ_VEC(IRQ_VEC), .TRC_VEC(TRC_VEC)) u_arb (
    .fiq_ok(fiq_pend & sr_q[FE_B]),
    .irq_ok(irq_pend & sr_q[IE_B]),
    .trc_ok(trc_pend),
    .src(src),
    .vec_addr(vec_addr)
  );

  assign take_any = run & ~insn_evt & (src != SRC_NONE);
  assign take_fiq = take_any & (src == SRC_FIQ);
  assign take_irq = take_any & (src == SRC_IRQ);
  assign take_trc = take_any & (src == SRC_TRC);
  assign pend_clr = {take_irq, take_fiq};

  assign bank_save[BK_FIQ] = take_fiq;
  assign bank_save[BK_IRQ] = take_irq | take_trc;
  assign bank_save[BK_SWI] = swi_go;

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      exc_shadow #(.PC_W(PC_W), .SR_W(SR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .save(bank_save[b]),
        .pc_in(cur_pc), .sr_in(sr_q),
        .pc_q(bank_pc[b]), .sr_q(bank_sr[b])
      );
    end
  endgenerate
  assign a14_out = bank_pc[BK_SWI];

  // trace request: one per completed instruction while TE is set
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        trc_pend <= 1'b0;
    else if (take_any)                 trc_pend <= 1'b0;
    else if (insn_retire && sr_q[TE_B]) trc_pend <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        st_q <= ST_RUN;
    else if (take_any) st_q <= ST_VEC;
    else               st_q <= ST_RUN;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sr_q <= '0;
    else if (run) begin
      if (ret_fiq)       sr_q <= bank_sr[BK_FIQ];
      else if (ret_irq)  sr_q <= bank_sr[BK_IRQ];
      else if (ret_swi)  sr_q <= bank_sr[BK_SWI];
      else if (swi_go || take_irq || take_trc) begin
        sr_q[PM_B] <= 1'b1;
        sr_q[IE_B] <= 1'b0;
        sr_q[TE_B] <= 1'b0;
      end else if (take_fiq) begin
        sr_q[PM_B] <= 1'b1;
        sr_q[FE_B] <= 1'b0;
        sr_q[IE_B] <= 1'b0;
        sr_q[TE_B] <= 1'b0;
      end else if (sr_we && !swi_valid) sr_q <= sr_wdata;
    end
  assign sr_out = sr_q;

  assign pm_rd_en   = take_any;
  assign pm_rd_addr = vec_addr;
  assign stall      = take_any | (st_q == ST_VEC);

  always_comb begin
    pc_load = 1'b0;
    pc_new  = '0;
    if (st_q == ST_VEC) begin
      pc_load = 1'b1;
      pc_new  = {{PAD_W{1'b0}}, pm_rd_data};
    end else if (ret_fiq) begin
      pc_load = 1'b1;
      pc_new  = bank_pc[BK_FIQ];
    end else if (ret_irq) begin
      pc_load = 1'b1;
      pc_new  = bank_pc[BK_IRQ];
    end else if (ret_swi) begin
      pc_load = 1'b1;
      pc_new  = bank_pc[BK_SWI];
    end else if (swi_go) begin
      pc_load = 1'b1;
      pc_new  = PC_W'({swi_imm, 2'b00});
    end
  end

  // R2
  vec_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pm_rd_en |=> (pc_load && stall && !pm_rd_en));
  // R2
  vec_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pm_rd_en |-> (pm_rd_addr == PC_W'(FIQ_VEC) || pm_rd_addr == PC_W'(IRQ_VEC)
                  || pm_rd_addr == PC_W'(TRC_VEC)));
  // R3
  fiq_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_rd_en && pm_rd_addr == PC_W'(FIQ_VEC)) |=>
      (sr_out[PM_B] && !sr_out[FE_B] && !sr_out[IE_B] && !sr_out[TE_B]));
  // R7
  swi_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swi_err |-> (!pc_load && !pm_rd_en));
  // R8
  fiq_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_rd_en && fiq_pend && sr_out[FE_B]) |-> (pm_rd_addr == PC_W'(FIQ_VEC)));
  // R9
  fiq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_pend && !sr_out[FE_B]) |=> fiq_pend);
  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !sr_out[IE_B]) |=> irq_pend);
endmodule

// File: tb/exc_seq_bench.sv
module exc_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fiq_n = 1'b1, irq_n = 1'b1, insn_retire = 1'b0;
  logic [21:0] cur_pc = '0;
  logic        swi_valid = 1'b0;
  logic [5:0]  swi_imm = '0;
  logic        ret_fiq = 1'b0, ret_irq = 1'b0, ret_swi = 1'b0;
  logic        sr_we = 1'b0;
  logic [3:0]  sr_wdata = '0;
  logic        pm_rd_en, stall, pc_load, swi_err;
  logic [21:0] pm_rd_addr, pc_new, a14_out;
  logic [15:0] pm_rd_data = '0;
  logic [3:0]  sr_out;
  logic [15:0] salt = 16'h0000;
  int          nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  exc_seq u_exc_seq (
    .clk(clk), .rst_n(rst_n), .fiq_n(fiq_n), .irq_n(irq_n),
    .insn_retire(insn_retire), .cur_pc(cur_pc), .swi_valid(swi_valid),
    .swi_imm(swi_imm), .ret_fiq(ret_fiq), .ret_irq(ret_irq), .ret_swi(ret_swi),
    .sr_we(sr_we), .sr_wdata(sr_wdata), .pm_rd_en(pm_rd_en),
    .pm_rd_addr(pm_rd_addr), .pm_rd_data(pm_rd_data), .stall(stall),
    .pc_load(pc_load), .pc_new(pc_new), .sr_out(sr_out), .a14_out(a14_out),
    .swi_err(swi_err)
  );

  function automatic logic [15:0] mem_word(input logic [21:0] a);
    return (a[15:0] * 16'h1357) ^ salt ^ 16'hA5C3;
  endfunction

  always @(posedge clk) if (pm_rd_en) pm_rd_data <= mem_word(pm_rd_addr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_sr(input logic [3:0] v);
    sr_we = 1'b1; sr_wdata = v;
    cyc();
    sr_we = 1'b0;
    #1;
  endtask

  task automatic wait_entry(output bit found);
    found = 0;
    for (int i = 0; i < 12; i++) begin
      #1;
      if (pm_rd_en) begin found = 1; return; end
      cyc();
    end
  endtask

  // checks both entry cycles and the status afterwards
  task automatic entry(input string req, input logic [21:0] vaddr, input logic [3:0] sr_exp);
    bit f;
    wait_entry(f);
    chk(f && stall && !pc_load, req, {31'b0, f}, 1);
    chk(pm_rd_addr == vaddr, req, pm_rd_addr, vaddr);
    cyc(); #1;
    chk(pc_load && stall && !pm_rd_en, req, {pc_load, stall, pm_rd_en}, 3'b110);
    chk(pc_new == {6'b0, mem_word(vaddr)}, req, pc_new, {6'b0, mem_word(vaddr)});
    cyc(); #1;
    chk(sr_out == sr_exp, req, sr_out, sr_exp);
    chk(!stall, req, stall, 0);
  endtask

  task automatic do_ret(input string req, input int which, input logic [21:0] pc_exp, input logic [3:0] sr_exp);
    ret_fiq = (which == 0); ret_irq = (which == 1); ret_swi = (which == 2);
    #1;
    chk(pc_load && pc_new == pc_exp, req, pc_new, pc_exp);
    cyc();
    ret_fiq = 0; ret_irq = 0; ret_swi = 0;
    #1;
    chk(sr_out == sr_exp, req, sr_out, sr_exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    bit f;
    logic [21:0] a14_prev;
    repeat (3) cyc();
    #1;
    // R1
    chk(sr_out == 0 && !pc_load && !stall && !pm_rd_en && !swi_err, "R1",
        {sr_out, pc_load, stall, pm_rd_en, swi_err}, 0);
    rst_n = 1'b1;
    cyc();

    // R11 status write
    write_sr(4'b0011);
    chk(sr_out == 4'b0011, "R11", sr_out, 4'b0011);

    // R2 R3 fast entry and return, swept over vector contents
    for (int k = 0; k < 4; k++) begin
      salt = 16'(k * 16'h2B1D);
      cur_pc = 22'h12345 + 22'(k * 977);
      fiq_n = 1'b0;
      entry("R2/R3", 22'd2, 4'b1000);
      fiq_n = 1'b1;
      repeat (3) cyc();
      do_ret("R3", 0, 22'h12345 + 22'(k * 977), 4'b0011);
    end

    // R4 normal entry keeps FE
    write_sr(4'b0111);
    cur_pc = 22'h2ABCD;
    irq_n = 1'b0;
    entry("R4", 22'd4, 4'b1001);
    irq_n = 1'b1;
    repeat (3) cyc();
    do_ret("R4", 1, 22'h2ABCD, 4'b0111);

    // R5 trace
    write_sr(4'b0100);
    cur_pc = 22'h0F00D;
    insn_retire = 1'b1;
    cyc();
    insn_retire = 1'b0;
    entry("R5", 22'd6, 4'b1000);
    do_ret("R5", 1, 22'h0F00D, 4'b0100);
    write_sr(4'b0011);

    // R6 R7 every immediate
    for (int n = 0; n < 64; n++) begin
      a14_prev = a14_out;
      cur_pc = 22'(n * 5003 + 100);
      swi_valid = 1'b1; swi_imm = 6'(n);
      #1;
      if (n < 2) begin
        chk(swi_err && !pc_load, "R7", {swi_err, pc_load}, 2'b10);
      end else begin
        chk(pc_load && !stall && !pm_rd_en && !swi_err, "R6", {pc_load, stall, pm_rd_en}, 3'b100);
        chk(pc_new == 22'(n * 4), "R6", pc_new, 22'(n * 4));
      end
      cyc();
      swi_valid = 1'b0;
      #1;
      if (n < 2) begin
        chk(sr_out == 4'b0011 && a14_out == a14_prev, "R7", a14_out, a14_prev);
      end else begin
        chk(sr_out == 4'b1001, "R6", sr_out, 4'b1001);
        chk(a14_out == 22'(n * 5003 + 100), "R6", a14_out, 22'(n * 5003 + 100));
        cur_pc = 22'h3FFFF;
        do_ret("R6", 2, 22'(n * 5003 + 100), 4'b0011);
      end
    end

    // R8 fast before normal
    salt = 16'h5A5A;
    fiq_n = 1'b0; irq_n = 1'b0;
    entry("R8", 22'd2, 4'b1000);
    fiq_n = 1'b1; irq_n = 1'b1;
    write_sr(4'b0010);
    entry("R8", 22'd4, 4'b1000);
    write_sr(4'b0000);

    // R9 gating, R10 single entry per edge
    fiq_n = 1'b0;
    f = 0;
    for (int i = 0; i < 8; i++) begin cyc(); #1; if (pm_rd_en) f = 1; end
    chk(!f, "R9", {31'b0, f}, 0);
    write_sr(4'b0001);
    entry("R9", 22'd2, 4'b1000);
    write_sr(4'b0001);
    f = 0;
    for (int i = 0; i < 10; i++) begin cyc(); #1; if (pm_rd_en) f = 1; end
    chk(!f, "R10", {31'b0, f}, 0);
    fiq_n = 1'b1;
    repeat (3) cyc();

    // R12 strobe beats acceptable interrupt
    write_sr(4'b0000);
    irq_n = 1'b0;
    repeat (6) cyc();
    irq_n = 1'b1;
    write_sr(4'b0010);
    ret_swi = 1'b1;
    #1;
    chk(pc_load && !pm_rd_en && pc_new == a14_out, "R12", {pc_load, pm_rd_en}, 2'b10);
    cyc();
    ret_swi = 1'b0;
    #1;
    chk(pm_rd_en && pm_rd_addr == 22'd4, "R12", pm_rd_addr, 22'd4);
    cyc(); cyc();

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule